// File: doc/BRIEF.md
# Radio Transceiver Burst Sequencer

This block walks the control lines of an external radio transceiver through one complete transmit or receive burst and back to power-down. A host pulses a transmit or a receive start request together with a configuration word. The sequencer then raises the regulator and transceiver power lines and waits for the supplies to come up. It shifts the configuration word out over a three-wire clock/data/enable programming port, waits for the synthesizer to settle, and finally raises the transmit-on or receive-on line.

In a transmit burst, a one-cycle ready strobe marks the moment the host should start sending preamble. A fixed time later, the active-low open-loop control line is pulled low to mark the start of modulation. In a receive burst, the open-loop line stays high for the whole burst. When the host signals end of burst, every control line drops together and a one-cycle done pulse reports that the transceiver is powered down again. All waits are cycle counts of the block clock (13.824 MHz by default) and are set by parameters. The RF data path is not part of this block.

Top module: `rf_burst_sequencer`

## Requirements
- R1: After reset every output is low: both power lines, the three programming lines, tx_on, rx_on, ole_n, data_ready and done.
- R2: A start request seen while powered down raises pwr_reg and pwr_trx in the next cycle, and prog_en rises exactly PWRUP_CYC cycles after the power lines rise.
- R3: Programming sends the word MSB first. Each bit lasts 2*HALF_CYC cycles, with prog_clk low for the first half and high for the second. prog_data changes only when prog_clk falls. prog_en stays high for the whole word. A transmit burst sends cfg_word[15:0] (16 bits) and a receive burst sends cfg_word[24:0] (25 bits).
- R4: In a transmit burst, tx_on rises exactly TX_SETTLE_CYC cycles after prog_en falls, and data_ready is high for exactly that one cycle.
- R5: In a transmit burst, ole_n is high from power-up onward and falls exactly MOD_DELAY_CYC cycles after tx_on rises. It then stays low until the burst ends.
- R6: In a receive burst, rx_on rises exactly RX_SETTLE_CYC cycles after prog_en falls, with data_ready high for that one cycle, and ole_n stays high for the whole burst.
- R7: burst_end sampled while tx_on or rx_on is high drops every control line in the next cycle and gives a done pulse exactly one cycle long.
- R8: A start request during a burst is ignored. burst_end is ignored while tx_on and rx_on are both low. Neither changes the burst timing or its outputs.
- R9: When start_tx and start_rx are both high in the same cycle, a transmit burst is run.
- R10: cfg_word is captured when the start request is accepted. Later changes to it do not alter the shifted word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock (13.824 MHz nominal) |
| rst | input | 1 | Synchronous active-high reset |
| start_tx | input | 1 | Request a transmit burst |
| start_rx | input | 1 | Request a receive burst |
| cfg_word | input | CFG_W | Configuration word, captured at start |
| burst_end | input | 1 | End the active burst |
| pwr_reg | output | 1 | Regulator power-up line |
| pwr_trx | output | 1 | Transceiver power-up line |
| prog_clk | output | 1 | Programming port clock |
| prog_data | output | 1 | Programming port data |
| prog_en | output | 1 | Programming port enable |
| tx_on | output | 1 | Transmitter on |
| rx_on | output | 1 | Receiver on |
| ole_n | output | 1 | Open-loop enable, active low |
| data_ready | output | 1 | One-cycle strobe when tx_on or rx_on rises |
| done | output | 1 | One-cycle pulse on return to power-down |

## Verification
The bench runs bursts from a vector table, each entry giving a mode and a configuration word. The entries cover an alternating-bit transmit word with junk in the upper bits, which checks that only the low 16 bits leave the block. They cover a single-LSB transmit word, which catches bit-order or off-by-one shift errors. They cover a dense 25-bit receive word, which checks the longer receive length, and a request with both starts high, which checks the transmit priority. Inside every burst, the bench raises a stray start with an inverted word during programming and a stray burst_end during settling. If either leaks into the design, it shows up as a changed word, a changed mode or a shifted timestamp.

// File: rtl/rfseq_pkg.sv
package rfseq_pkg;
  typedef enum logic [2:0] {
    ST_OFF    = 3'd0,
    ST_PWRUP  = 3'd1,
    ST_PROG   = 3'd2,
    ST_SETTLE = 3'd3,
    ST_TX_PRE = 3'd4,
    ST_TX_MOD = 3'd5,
    ST_RX_ACT = 3'd6
  } seq_state_t;
endpackage

// File: rtl/rfseq_timer.sv
module rfseq_timer #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] val,
  output logic         zero
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                cnt_q <= '0;
    else if (load)          cnt_q <= val;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);

  // counter never wraps: once at zero it stays there until reloaded
  p_no_wrap_r2: assert property (@(posedge clk) disable iff (rst)
    (zero && !load) |=> zero);
endmodule

// File: rtl/rfseq_shifter.sv
module rfseq_shifter #(
  parameter int CFG_W    = 25,
  parameter int HALF_CYC = 2,
  localparam int BW  = $clog2(CFG_W + 1),
  localparam int HCW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             go,
  input  logic [BW-1:0]    nbits,
  input  logic [CFG_W-1:0] word,
  output logic             sclk,
  output logic             sdata,
  output logic             sen,
  output logic             fin
);
  logic [CFG_W-1:0] sh_q;
  logic [BW-1:0]    left_q;
  logic [HCW-1:0]   ph_q;
  logic             sclk_q, sen_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q   <= '0;
      left_q <= '0;
      ph_q   <= '0;
      sclk_q <= 1'b0;
      sen_q  <= 1'b0;
    end else if (go) begin
      // left-align the active bits so the MSB of the word leaves first
      sh_q   <= word << (CFG_W - int'(nbits));
      left_q <= nbits;
      ph_q   <= HCW'(HALF_CYC - 1);
      sclk_q <= 1'b0;
      sen_q  <= 1'b1;
    end else if (sen_q) begin
      if (ph_q == '0) begin
        ph_q <= HCW'(HALF_CYC - 1);
        if (!sclk_q) begin
          sclk_q <= 1'b1;
        end else begin
          sclk_q <= 1'b0;
          left_q <= left_q - 1'b1;
          if (left_q == BW'(1)) begin
            sen_q <= 1'b0;
            sh_q  <= '0;
          end else begin
            sh_q <= sh_q << 1;
          end
        end
      end else begin
        ph_q <= ph_q - 1'b1;
      end
    end
  end

  assign sclk  = sclk_q;
  assign sdata = sh_q[CFG_W-1];
  assign sen   = sen_q;
  assign fin   = sen_q && sclk_q && (ph_q == '0) && (left_q == BW'(1));

  // data may only move on the falling edge of the programming clock
  p_data_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (sclk_q && $past(sclk_q)) |-> $stable(sh_q[CFG_W-1]));
  // the clock only toggles while enable is asserted
  p_clk_in_frame_r3: assert property (@(posedge clk) disable iff (rst)
    sclk_q |-> sen_q);
endmodule

// File: rtl/rf_burst_sequencer.sv
module rf_burst_sequencer
  import rfseq_pkg::*;
#(
  parameter int CFG_W         = 25,
  parameter int TX_BITS       = 16,
  parameter int RX_BITS       = 25,
  parameter int HALF_CYC      = 2,
  parameter int PWRUP_CYC     = 553,
  parameter int TX_SETTLE_CYC = 2765,
  parameter int RX_SETTLE_CYC = 2074,
  parameter int MOD_DELAY_CYC = 692
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_tx,
  input  logic             start_rx,
  input  logic [CFG_W-1:0] cfg_word,
  input  logic             burst_end,
  output logic             pwr_reg,
  output logic             pwr_trx,
  output logic             prog_clk,
  output logic             prog_data,
  output logic             prog_en,
  output logic             tx_on,
  output logic             rx_on,
  output logic             ole_n,
  output logic             data_ready,
  output logic             done
);
  localparam int M1   = (PWRUP_CYC > TX_SETTLE_CYC) ? PWRUP_CYC : TX_SETTLE_CYC;
  localparam int M2   = (RX_SETTLE_CYC > MOD_DELAY_CYC) ? RX_SETTLE_CYC : MOD_DELAY_CYC;
  localparam int MAXC = (M1 > M2) ? M1 : M2;
  localparam int TW   = $clog2(MAXC + 1);
  localparam int BW   = $clog2(CFG_W + 1);

  seq_state_t       state_q, state_d;
  logic             mode_tx_q;
  logic [CFG_W-1:0] cfg_q;
  logic             tload, tzero, go, fin, accept;
  logic [TW-1:0]    tval;
  logic             pwr_q, tx_q, rx_q, ole_q, rdy_q, done_q;

  rfseq_timer #(.W(TW)) u_timer (
    .clk(clk), .rst(rst), .load(tload), .val(tval), .zero(tzero)
  );

  rfseq_shifter #(.CFG_W(CFG_W), .HALF_CYC(HALF_CYC)) u_shift (
    .clk(clk), .rst(rst), .go(go),
    .nbits(mode_tx_q ? BW'(TX_BITS) : BW'(RX_BITS)),
    .word(cfg_q),
    .sclk(prog_clk), .sdata(prog_data), .sen(prog_en), .fin(fin)
  );

  always_comb begin
    state_d = state_q;
    tload   = 1'b0;
    tval    = '0;
    go      = 1'b0;
    accept  = 1'b0;
    case (state_q)
      ST_OFF: if (start_tx || start_rx) begin
        state_d = ST_PWRUP;
        accept  = 1'b1;
        tload   = 1'b1;
        tval    = TW'(PWRUP_CYC - 1);
      end
      ST_PWRUP: if (tzero) begin
        state_d = ST_PROG;
        go      = 1'b1;
      end
      ST_PROG: if (fin) begin
        state_d = ST_SETTLE;
        tload   = 1'b1;
        tval    = mode_tx_q ? TW'(TX_SETTLE_CYC - 1) : TW'(RX_SETTLE_CYC - 1);
      end
      ST_SETTLE: if (tzero) begin
        if (mode_tx_q) begin
          state_d = ST_TX_PRE;
          tload   = 1'b1;
          tval    = TW'(MOD_DELAY_CYC - 1);
        end else begin
          state_d = ST_RX_ACT;
        end
      end
      ST_TX_PRE: begin
        if (burst_end)  state_d = ST_OFF;
        else if (tzero) state_d = ST_TX_MOD;
      end
      ST_TX_MOD, ST_RX_ACT: if (burst_end) state_d = ST_OFF;
      default: state_d = ST_OFF;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_OFF;
      mode_tx_q <= 1'b0;
      cfg_q     <= '0;
      pwr_q     <= 1'b0;
      tx_q      <= 1'b0;
      rx_q      <= 1'b0;
      ole_q     <= 1'b0;
      rdy_q     <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        mode_tx_q <= start_tx;
        cfg_q     <= cfg_word;
      end
      pwr_q  <= (state_d != ST_OFF);
      tx_q   <= (state_d == ST_TX_PRE) || (state_d == ST_TX_MOD);
      rx_q   <= (state_d == ST_RX_ACT);
      ole_q  <= (state_d != ST_OFF) && (state_d != ST_TX_MOD);
      rdy_q  <= (state_q == ST_SETTLE) &&
                ((state_d == ST_TX_PRE) || (state_d == ST_RX_ACT));
      done_q <= (state_q != ST_OFF) && (state_d == ST_OFF);
    end
  end

  assign pwr_reg    = pwr_q;
  assign pwr_trx    = pwr_q;
  assign tx_on      = tx_q;
  assign rx_on      = rx_q;
  assign ole_n      = ole_q;
  assign data_ready = rdy_q;
  assign done       = done_q;

  p_prog_powered_r2: assert property (@(posedge clk) disable iff (rst)
    prog_en |-> pwr_trx);
  p_on_exclusive_r9: assert property (@(posedge clk) disable iff (rst)
    !(tx_on && rx_on));
  p_on_after_prog_r4: assert property (@(posedge clk) disable iff (rst)
    (tx_on || rx_on) |-> !prog_en);
  p_ready_at_on_r6: assert property (@(posedge clk) disable iff (rst)
    data_ready |-> $rose(tx_on || rx_on));
  p_open_loop_tx_only_r5: assert property (@(posedge clk) disable iff (rst)
    (pwr_reg && !ole_n) |-> tx_on);
  p_done_on_drop_r7: assert property (@(posedge clk) disable iff (rst)
    done |-> (!pwr_reg && !tx_on && !rx_on && $past(pwr_reg)));
  p_done_single_r7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  p_start_ignored_r8: assert property (@(posedge clk) disable iff (rst)
    (prog_en && $past(prog_en)) |-> $stable(mode_tx_q));
endmodule

// File: tb/tb_rf_burst_sequencer.sv
module tb_rf_burst_sequencer;
  localparam int CFG_W = 25;
  localparam int PW    = 8;
  localparam int TXS   = 20;
  localparam int RXS   = 15;
  localparam int MOD   = 6;
  localparam int HALF  = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_tx = 1'b0, start_rx = 1'b0, burst_end = 1'b0;
  logic [CFG_W-1:0] cfg_word = '0;
  logic pwr_reg, pwr_trx, prog_clk, prog_data, prog_en;
  logic tx_on, rx_on, ole_n, data_ready, done;

  int total = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  rf_burst_sequencer #(
    .CFG_W(CFG_W), .TX_BITS(16), .RX_BITS(25), .HALF_CYC(HALF),
    .PWRUP_CYC(PW), .TX_SETTLE_CYC(TXS), .RX_SETTLE_CYC(RXS),
    .MOD_DELAY_CYC(MOD)
  ) dut (
    .clk(clk), .rst(rst), .start_tx(start_tx), .start_rx(start_rx),
    .cfg_word(cfg_word), .burst_end(burst_end),
    .pwr_reg(pwr_reg), .pwr_trx(pwr_trx), .prog_clk(prog_clk),
    .prog_data(prog_data), .prog_en(prog_en), .tx_on(tx_on),
    .rx_on(rx_on), .ole_n(ole_n), .data_ready(data_ready), .done(done)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int outs_vec();
    return {pwr_reg, pwr_trx, prog_clk, prog_data, prog_en,
            tx_on, rx_on, ole_n, data_ready, done};
  endfunction

  // fields: {request tx, request both, word}
  localparam logic [26:0] VEC [4] = '{
    {1'b1, 1'b0, 25'h1F0A5A5},
    {1'b1, 1'b0, 25'h0000001},
    {1'b0, 1'b0, 25'h15ACE37},
    {1'b0, 1'b1, 25'h0C3F00F}
  };

  task automatic run_burst(input logic is_tx, input logic both, input logic [CFG_W-1:0] w);
    int t = 1, t_en_r = -1, t_en_f = -1, t_on = -1, t_ole = -1;
    int t_rdy = -1, nrdy = 0, ncap = 0, t_end = -1, nb, settle;
    logic [CFG_W-1:0] cap = '0, expw;
    logic pclk = 1'b0, pdat = 1'b0, glitch = 1'b0, saw_tx = 1'b0, saw_rx = 1'b0;
    logic exp_tx;
    exp_tx = is_tx | both;
    nb     = exp_tx ? 16 : 25;
    settle = exp_tx ? TXS : RXS;
    expw   = exp_tx ? {9'b0, w[15:0]} : w;

    @(negedge clk);
    start_tx = is_tx | both;
    start_rx = ~is_tx | both;
    cfg_word = w;
    @(negedge clk);
    start_tx = 1'b0;
    start_rx = 1'b0;
    chk(pwr_reg && pwr_trx && !prog_en, "R2 power lines after start", {pwr_reg, pwr_trx, prog_en}, 3'b110);
    chk(ole_n, "R5 ole_n high at power-up", ole_n, 1);

    while (t < 3000) begin
      if (prog_en && t_en_r < 0) t_en_r = t;
      if (!prog_en && t_en_r >= 0 && t_en_f < 0) t_en_f = t;
      if (prog_clk && !pclk) begin cap = {cap[CFG_W-2:0], prog_data}; ncap++; end
      if (prog_clk && pclk && (prog_data != pdat)) glitch = 1'b1;
      pclk = prog_clk;
      pdat = prog_data;
      if ((tx_on || rx_on) && t_on < 0) t_on = t;
      if (data_ready) begin nrdy++; t_rdy = t; end
      if (pwr_reg && !ole_n && t_ole < 0) t_ole = t;
      if (tx_on) saw_tx = 1'b1;
      if (rx_on) saw_rx = 1'b1;
      if (t == t_end) break;
      burst_end = 1'b0;
      start_tx  = 1'b0;
      start_rx  = 1'b0;
      if (t_en_r >= 0 && t == t_en_r + 3) begin
        start_tx = 1'b1; start_rx = 1'b1; cfg_word = ~w;   // R8 R10 stray request
      end
      if (t_en_f >= 0 && t == t_en_f + 2) burst_end = 1'b1;  // R8 early end ignored
      if (t_on >= 0 && t == t_on + MOD + 3) begin
        burst_end = 1'b1;
        t_end = t + 1;
      end
      @(negedge clk);
      t++;
    end
    burst_end = 1'b0;

    chk(t_en_r == PW + 1, "R2 prog_en delay", t_en_r, PW + 1);
    chk(ncap == nb, "R3 bit count", ncap, nb);
    chk(cap == expw, "R3 R10 shifted word", cap, expw);
    chk(!glitch, "R3 data stable while clock high", glitch, 0);
    chk(t_en_f - t_en_r == nb * 2 * HALF, "R3 enable frame length", t_en_f - t_en_r, nb * 2 * HALF);
    chk(t_on - t_en_f == settle, exp_tx ? "R4 tx_on settle" : "R6 rx_on settle", t_on - t_en_f, settle);
    chk(nrdy == 1 && t_rdy == t_on, "R4 R6 data_ready strobe", t_rdy, t_on);
    if (exp_tx) chk(t_ole - t_on == MOD, "R5 ole_n fall delay", t_ole - t_on, MOD);
    else        chk(t_ole < 0, "R6 ole_n high in receive", t_ole, -1);
    chk(exp_tx ? (saw_tx && !saw_rx) : (saw_rx && !saw_tx), "R9 burst mode",
        {saw_tx, saw_rx}, exp_tx ? 2 : 1);
    chk(outs_vec() == 10'b0000000001, "R7 lines low with done", outs_vec(), 1);
    @(negedge clk);
    chk(!done && !pwr_reg, "R7 done single cycle", done, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(outs_vec() == 0, "R1 reset outputs", outs_vec(), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(outs_vec() == 0, "R1 idle after reset", outs_vec(), 0);

    for (int i = 0; i < 4; i++)
      run_burst(VEC[i][26], VEC[i][25], VEC[i][24:0]);

    // R8: end-of-burst while powered down has no effect
    burst_end = 1'b1;
    @(negedge clk);
    burst_end = 1'b0;
    chk(outs_vec() == 0, "R8 burst_end idle ignored", outs_vec(), 0);
    @(negedge clk);
    chk(outs_vec() == 0, "R8 no done from idle end", outs_vec(), 0);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule